// File: doc/BRIEF.md
# Disk Controller Host Data Port

This block is the byte-wide data port between a host and the core of a floppy-style disk controller. Command parameter bytes, result bytes and sector data all pass through it. In command and result phases, and in the execution phase when the FIFO is switched off, it behaves as a single-byte holding register. In the execution phase with the FIFO switched on, it buffers up to 16 bytes and raises a service request for DMA or interrupt handling when a programmed threshold is reached. The threshold sets how much bus latency the host can tolerate. The allowed delay is the threshold times eight bit times at the disk data rate, minus 1.5 µs. For example, at 1 Mbps a threshold of 8 allows 62.5 µs.

The host side has two streams. Host writes use `hw_valid`/`hw_ready`, and host reads use `hr_valid`/`hr_ready`. A byte moves only in a cycle where valid and ready are both high. The port never holds a host beat that was not accepted. The plain status bits `rqm` (the port can move a byte now) and `dio` (the direction of transfer) say which of the two streams is open. The controller side is a pair of strobes with no back-pressure: `core_in_stb` delivers a byte toward the host, and `core_out_stb` takes a byte toward the disk. In the execution phase these strobes come from the disk stream, and missing one is a data error. A delivery into a full port is an overrun. A request from an empty port is an underrun, and the port then pads the rest of the sector with zero bytes.

Top module: `disk_data_port`

## Requirements
- R1: After reset the FIFO is disabled, the port is empty, `dio`=0, `rqm`=1, and `svc_req`, `err_overrun`, `err_underrun` and `pad_active` are 0. Without a configure operation, execution-phase transfers use one byte of capacity.
- R2: A cycle with `cfg_load`=1 latches `cfg_fifo_en` and `cfg_thresh`. A threshold of 0 acts as 1. The FIFO takes effect only in the execution phase; in the command phase the capacity stays one byte even when the FIFO is enabled.
- R3: When the FIFO is not in effect, the capacity is one byte. When `dio`=0, `rqm` is high while the port is empty. When `dio`=1, `rqm` is high while it holds a byte.
- R4: The `phase` input is coded 0 = command, 1 = execution, 2 = result, and 3 is treated as command. `dio` is 1 in the result phase, and in the execution phase when `exec_read`=1; otherwise it is 0.
- R5: A cycle in which `phase` differs from its value in the previous cycle flushes the buffer and clears both error flags and the sector byte count. In that cycle `rqm` and `svc_req` are 0 and no byte moves.
- R6: In the execution phase with the FIFO enabled, the port holds up to 16 bytes and delivers them in arrival order.
- R7: `svc_req` is high only in the execution phase. For a read it is high when the count of stored bytes is at least the threshold. For a write it is high when the free space (16 minus stored) is at least the threshold. With the FIFO off the threshold is 1 and the capacity is 1.
- R8: A `core_in_stb` in the execution phase with `dio`=1 and the port full sets `err_overrun`, which stays set until the next phase change. That byte and all later `core_in_stb` bytes are dropped. The host can still drain every stored byte, and `svc_req` then uses a threshold of 1.
- R9: A `core_out_stb` in the execution phase with `dio`=0 and the port empty sets `err_underrun`, which stays set until the next phase change. While it is set, `hw_ready` is 0.
- R10: On a `core_out_stb` with the port empty, and after an underrun, `core_out_data` is 0x00. `pad_active` is high while `err_underrun` is set and fewer than `SECTOR_BYTES` execution-phase `core_out_stb` strobes have occurred since the phase began.
- R11: A host write offered while `hw_ready`=0, including one offered against the direction of transfer, leaves the stored bytes unchanged. A controller strobe that finds the port full or empty outside the execution phase is ignored and sets no error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Latch FIFO enable and threshold |
| cfg_fifo_en | input | 1 | FIFO enable value to latch |
| cfg_thresh | input | 4 | Service threshold to latch (1..15; 0 acts as 1) |
| phase | input | 2 | Sequencer phase: 0 command, 1 execution, 2 result |
| exec_read | input | 1 | Execution-phase direction, 1 = disk to host |
| hw_valid | input | 1 | Host write byte valid |
| hw_data | input | 8 | Host write byte |
| hw_ready | output | 1 | Port accepts a host write |
| hr_valid | output | 1 | Host read byte available |
| hr_data | output | 8 | Host read byte (oldest stored) |
| hr_ready | input | 1 | Host takes the read byte |
| rqm | output | 1 | Port can move a byte in the direction of `dio` |
| dio | output | 1 | 1 = controller to host, 0 = host to controller |
| svc_req | output | 1 | DMA/interrupt service request |
| core_in_stb | input | 1 | Controller-side byte delivered toward host |
| core_in_data | input | 8 | Byte delivered with `core_in_stb` |
| core_out_stb | input | 1 | Controller side takes a byte toward disk |
| core_out_data | output | 8 | Byte for the controller side (0x00 when empty or padding) |
| err_overrun | output | 1 | Sticky overrun flag |
| err_underrun | output | 1 | Sticky underrun flag |
| pad_active | output | 1 | Sector is being completed with zero bytes |

## Verification
The hardest states to reach are the exact free-space and fill levels where `svc_req` changes, because each depends on the threshold and the direction together. The bench therefore sweeps every threshold from 1 to 15 in both directions. In each sweep it fills the port one byte at a time and checks the request after every byte against the count it tracks itself. Each sweep then runs past the limit on purpose: a 17th disk byte in a read forces an overrun and a drain of all 16 stored bytes, and an extra disk request after 16 bytes in a write forces an underrun followed by a zero-padded remainder of a short sector.

// File: rtl/dfp_pkg.sv
`timescale 1ns/1ps
package dfp_pkg;
  typedef enum logic [1:0] {
    PH_CMD   = 2'd0,
    PH_EXEC  = 2'd1,
    PH_RES   = 2'd2,
    PH_SPARE = 2'd3
  } phase_e;
endpackage

// File: rtl/dfp_cfg.sv
`timescale 1ns/1ps
module dfp_cfg #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          en_in,
  input  logic [TW-1:0] thr_in,
  output logic          en_q,
  output logic [TW-1:0] thr_eff
);
  logic [TW-1:0] thr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      thr_q <= TW'(1);
    end else if (load) begin
      en_q  <= en_in;
      thr_q <= thr_in;
    end
  end

  assign thr_eff = (thr_q == '0) ? TW'(1) : thr_q;
endmodule

// File: rtl/dfp_fifo.sv
`timescale 1ns/1ps
module dfp_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [DW-1:0]              wdata,
  input  logic                       pop,
  output logic [DW-1:0]              head,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  assign head = mem[rd_ptr];
endmodule

// File: rtl/dfp_xfer.sv
`timescale 1ns/1ps
module dfp_xfer #(
  parameter int SECTOR_BYTES = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic set_ovr,
  input  logic set_udr,
  input  logic out_stb,
  output logic err_ovr,
  output logic err_udr,
  output logic pad_active
);
  localparam int SW = $clog2(SECTOR_BYTES + 1);
  localparam logic [SW-1:0] SEC_LAST = SW'(SECTOR_BYTES);

  logic [SW-1:0] sec_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      sec_q   <= '0;
      err_ovr <= 1'b0;
      err_udr <= 1'b0;
    end else begin
      if (out_stb && sec_q != SEC_LAST) sec_q <= sec_q + SW'(1);
      if (set_ovr) err_ovr <= 1'b1;
      if (set_udr) err_udr <= 1'b1;
    end
  end

  assign pad_active = err_udr && (sec_q < SEC_LAST);
endmodule

// File: rtl/disk_data_port.sv
`timescale 1ns/1ps
module disk_data_port #(
  parameter int DEPTH        = 16,
  parameter int DW           = 8,
  parameter int SECTOR_BYTES = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic          cfg_fifo_en,
  input  logic [3:0]    cfg_thresh,
  input  logic [1:0]    phase,
  input  logic          exec_read,
  input  logic          hw_valid,
  input  logic [DW-1:0] hw_data,
  output logic          hw_ready,
  output logic          hr_valid,
  output logic [DW-1:0] hr_data,
  input  logic          hr_ready,
  output logic          rqm,
  output logic          dio,
  output logic          svc_req,
  input  logic          core_in_stb,
  input  logic [DW-1:0] core_in_data,
  input  logic          core_out_stb,
  output logic [DW-1:0] core_out_data,
  output logic          err_overrun,
  output logic          err_underrun,
  output logic          pad_active
);
  import dfp_pkg::*;

  localparam int CW = $clog2(DEPTH + 1);
  localparam int TW = 4;
  localparam logic [CW-1:0] CAP_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] CAP_ONE  = CW'(1);

  phase_e        ph, phase_q;
  logic          phase_chg, in_exec, fifo_active;
  logic          cfg_en_q;
  logic [TW-1:0] thr_eff, eth;
  logic [CW-1:0] count, cap, free_sp;
  logic [DW-1:0] head;
  logic          full, empty;
  logic          push_host, pop_host, push_core, pop_core;
  logic          push, pop;
  logic          set_ovr, set_udr, out_stb_exec;

  assign ph = phase_e'(phase);

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_CMD;
    else        phase_q <= ph;
  end

  assign phase_chg = (ph != phase_q);
  assign in_exec   = (ph == PH_EXEC);

  dfp_cfg #(.TW(TW)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cfg_load),
    .en_in   (cfg_fifo_en),
    .thr_in  (cfg_thresh),
    .en_q    (cfg_en_q),
    .thr_eff (thr_eff)
  );

  assign fifo_active = cfg_en_q && in_exec;
  assign cap         = fifo_active ? CAP_FULL : CAP_ONE;
  assign full        = (count >= cap);
  assign empty       = (count == '0);
  assign free_sp     = full ? '0 : (cap - count);

  // direction and request-for-master
  assign dio = (ph == PH_RES) || (in_exec && exec_read);

  always_comb begin
    if (phase_chg)  rqm = 1'b0;
    else if (dio)   rqm = !empty;
    else            rqm = !full && !err_underrun;
  end

  assign hw_ready = rqm && !dio;
  assign hr_valid = rqm && dio;
  assign hr_data  = head;

  // byte movement
  assign push_host = hw_valid && hw_ready;
  assign pop_host  = hr_valid && hr_ready;
  assign push_core = dio && core_in_stb && !full && !phase_chg && !err_overrun;
  assign pop_core  = !dio && core_out_stb && !empty && !phase_chg && !err_underrun;
  assign push      = push_host || push_core;
  assign pop       = pop_host || pop_core;

  // disk-side error detection, execution phase only
  assign set_ovr      = in_exec && dio && core_in_stb && full && !phase_chg;
  assign set_udr      = in_exec && !dio && core_out_stb && empty && !phase_chg;
  assign out_stb_exec = in_exec && !dio && core_out_stb && !phase_chg;

  dfp_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (phase_chg),
    .push  (push),
    .wdata (dio ? core_in_data : hw_data),
    .pop   (pop),
    .head  (head),
    .count (count)
  );

  dfp_xfer #(.SECTOR_BYTES(SECTOR_BYTES)) u_xfer (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (phase_chg),
    .set_ovr    (set_ovr),
    .set_udr    (set_udr),
    .out_stb    (out_stb_exec),
    .err_ovr    (err_overrun),
    .err_udr    (err_underrun),
    .pad_active (pad_active)
  );

  assign core_out_data = (empty || err_underrun) ? '0 : head;

  // service request
  assign eth = (!fifo_active || err_overrun) ? TW'(1) : thr_eff;

  always_comb begin
    if (!in_exec || phase_chg) svc_req = 1'b0;
    else if (dio)              svc_req = (count >= CW'(eth));
    else                       svc_req = !err_underrun && (free_sp >= CW'(eth));
  end
endmodule

// File: rtl/dfp_port_chk.sv
`timescale 1ns/1ps
module dfp_port_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    phase,
  input logic [1:0]    phase_q,
  input logic [CW-1:0] count,
  input logic          cfg_en_q,
  input logic          dio,
  input logic          rqm,
  input logic          hw_ready,
  input logic          hr_valid,
  input logic          svc_req,
  input logic          err_overrun,
  input logic          err_underrun,
  input logic          pad_active,
  input logic [DW-1:0] core_out_data
);
  // R1
  reset_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !cfg_en_q);

  // R3
  single_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != 2'd1) && (phase == phase_q) |-> count <= CW'(1));

  // R3
  host_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_ready |-> (rqm && !dio && !hr_valid));

  // R4
  result_dio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd2) |-> dio);

  // R5
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != phase_q) |=> (count == '0 && !err_overrun && !err_underrun));

  // R6
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R7
  svc_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> (phase == 2'd1));

  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_overrun && (phase == phase_q) |=> err_overrun);

  // R9
  udr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_underrun |-> !hw_ready);

  // R10
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pad_active |-> (core_out_data == '0));
endmodule

bind disk_data_port dfp_port_chk #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .phase         (phase),
  .phase_q       (phase_q),
  .count         (count),
  .cfg_en_q      (cfg_en_q),
  .dio           (dio),
  .rqm           (rqm),
  .hw_ready      (hw_ready),
  .hr_valid      (hr_valid),
  .svc_req       (svc_req),
  .err_overrun   (err_overrun),
  .err_underrun  (err_underrun),
  .pad_active    (pad_active),
  .core_out_data (core_out_data)
);

// File: tb/disk_data_port_tb.sv
`timescale 1ns/1ps
module disk_data_port_tb;
  localparam int SEC = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_load = 0, cfg_fifo_en = 0;
  logic [3:0] cfg_thresh = 0;
  logic [1:0] phase = 0;
  logic       exec_read = 0;
  logic       hw_valid = 0;
  logic [7:0] hw_data = 0;
  logic       hw_ready, hr_valid, rqm, dio, svc_req;
  logic [7:0] hr_data, core_out_data;
  logic       hr_ready = 0;
  logic       core_in_stb = 0, core_out_stb = 0;
  logic [7:0] core_in_data = 0;
  logic       err_overrun, err_underrun, pad_active;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  disk_data_port #(.DEPTH(16), .DW(8), .SECTOR_BYTES(SEC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_fifo_en(cfg_fifo_en),
    .cfg_thresh(cfg_thresh), .phase(phase), .exec_read(exec_read),
    .hw_valid(hw_valid), .hw_data(hw_data), .hw_ready(hw_ready),
    .hr_valid(hr_valid), .hr_data(hr_data), .hr_ready(hr_ready),
    .rqm(rqm), .dio(dio), .svc_req(svc_req),
    .core_in_stb(core_in_stb), .core_in_data(core_in_data),
    .core_out_stb(core_out_stb), .core_out_data(core_out_data),
    .err_overrun(err_overrun), .err_underrun(err_underrun), .pad_active(pad_active)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic set_phase(input logic [1:0] p, input logic rd);
    phase = p; exec_read = rd;
    step();
  endtask

  task automatic cfg(input logic en, input logic [3:0] t);
    cfg_load = 1; cfg_fifo_en = en; cfg_thresh = t;
    step();
    cfg_load = 0;
  endtask

  task automatic host_wr(input logic [7:0] d);
    hw_valid = 1; hw_data = d;
    step();
    hw_valid = 0;
  endtask

  task automatic host_rd(input string req, input logic [7:0] exp);
    #1;
    chk(req, "hr_valid before read", int'(hr_valid), 1);
    chk(req, "hr_data", int'(hr_data), int'(exp));
    hr_ready = 1;
    step();
    hr_ready = 0;
  endtask

  task automatic disk_in(input logic [7:0] d);
    core_in_stb = 1; core_in_data = d;
    step();
    core_in_stb = 0;
  endtask

  task automatic disk_out(input string req, input logic [7:0] exp);
    #1;
    chk(req, "core_out_data", int'(core_out_data), int'(exp));
    core_out_stb = 1;
    step();
    core_out_stb = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    // R1 reset state
    chk("R1", "rqm", int'(rqm), 1);
    chk("R1", "dio", int'(dio), 0);
    chk("R1", "svc_req", int'(svc_req), 0);
    chk("R1", "err_overrun", int'(err_overrun), 0);
    chk("R1", "err_underrun", int'(err_underrun), 0);
    chk("R1", "pad_active", int'(pad_active), 0);
    // R1 exec without configure: single byte capacity
    set_phase(2'd1, 1'b0);
    host_wr(8'h21);
    chk("R1", "hw_ready after one byte, fifo off", int'(hw_ready), 0);

    // R3 command phase single-byte handshake, R11 ignored write
    set_phase(2'd0, 1'b0);
    chk("R3", "cmd rqm empty", int'(rqm), 1);
    host_wr(8'h3C);
    chk("R3", "cmd rqm holding", int'(rqm), 0);
    host_wr(8'h55);
    disk_out("R11", 8'h3C);
    chk("R3", "cmd rqm after take", int'(rqm), 1);
    core_out_stb = 1; step(); core_out_stb = 0;
    chk("R11", "no underrun outside exec", int'(err_underrun), 0);

    // R4/R3 result phase
    set_phase(2'd2, 1'b0);
    chk("R4", "result dio", int'(dio), 1);
    chk("R3", "result rqm empty", int'(rqm), 0);
    disk_in(8'hA5);
    chk("R3", "result rqm holding", int'(rqm), 1);
    disk_in(8'h11);
    chk("R11", "no overrun outside exec", int'(err_overrun), 0);
    host_rd("R3", 8'hA5);
    chk("R3", "result empty after read", int'(hr_valid), 0);
    set_phase(2'd3, 1'b0);
    chk("R4", "phase 3 dio", int'(dio), 0);

    // R2 fifo enabled has no effect in command phase
    cfg(1'b1, 4'd4);
    set_phase(2'd0, 1'b0);
    host_wr(8'h01);
    chk("R2", "cmd capacity one with fifo on", int'(hw_ready), 0);

    // R6 R7 R8 read sweep over thresholds
    for (int t = 1; t <= 15; t++) begin
      cfg(1'b1, 4'(t));
      set_phase(2'd0, 1'b0);
      set_phase(2'd1, 1'b1);
      chk("R5", "empty at exec entry", int'(hr_valid), 0);
      for (int k = 0; k < 16; k++) begin
        disk_in(8'((t * 16 + k) & 255));
        chk("R7", "read svc_req level", int'(svc_req), int'((k + 1) >= t));
      end
      chk("R6", "no overrun at 16", int'(err_overrun), 0);
      disk_in(8'hFF);
      chk("R8", "overrun flag", int'(err_overrun), 1);
      disk_in(8'hFE);
      chk("R8", "svc after overrun", int'(svc_req), 1);
      for (int k = 0; k < 16; k++) host_rd("R8", 8'((t * 16 + k) & 255));
      chk("R8", "drained", int'(hr_valid), 0);
      chk("R8", "overrun sticky", int'(err_overrun), 1);
    end
    set_phase(2'd2, 1'b0);
    chk("R5", "overrun cleared by phase change", int'(err_overrun), 0);

    // R11 wrong-direction host write in exec read
    set_phase(2'd1, 1'b1);
    disk_in(8'h77);
    #1 chk("R11", "hw_ready in read", int'(hw_ready), 0);
    host_wr(8'h99);
    host_rd("R11", 8'h77);
    chk("R11", "only one byte stored", int'(hr_valid), 0);

    // R5 flush with data present
    disk_in(8'h10); disk_in(8'h20); disk_in(8'h30);
    set_phase(2'd2, 1'b0);
    chk("R5", "flushed on phase change", int'(hr_valid), 0);

    // R6 R7 R9 R10 write sweep
    for (int t = 1; t <= 15; t++) begin
      cfg(1'b1, 4'(t));
      set_phase(2'd0, 1'b0);
      set_phase(2'd1, 1'b0);
      for (int k = 0; k < 16; k++) begin
        chk("R7", "write svc_req level", int'(svc_req), int'((16 - k) >= t));
        host_wr(8'((t * 7 + k) & 255));
      end
      chk("R7", "write svc_req full", int'(svc_req), 0);
      chk("R6", "hw_ready full", int'(hw_ready), 0);
      host_wr(8'hEE);
      for (int k = 0; k < 16; k++) disk_out("R6", 8'((t * 7 + k) & 255));
      chk("R9", "no underrun yet", int'(err_underrun), 0);
      disk_out("R10", 8'h00);
      chk("R9", "underrun flag", int'(err_underrun), 1);
      chk("R9", "hw_ready blocked", int'(hw_ready), 0);
      for (int s = 17; s < SEC; s++) begin
        chk("R10", "pad_active during sector", int'(pad_active), 1);
        disk_out("R10", 8'h00);
      end
      chk("R10", "pad_active at sector end", int'(pad_active), 0);
    end

    // R7 bypass exec read, R8 overrun at one byte
    cfg(1'b0, 4'd5);
    set_phase(2'd0, 1'b0);
    set_phase(2'd1, 1'b1);
    chk("R7", "bypass svc empty", int'(svc_req), 0);
    disk_in(8'h4A);
    chk("R7", "bypass svc one byte", int'(svc_req), 1);
    disk_in(8'h4B);
    chk("R8", "bypass overrun", int'(err_overrun), 1);
    host_rd("R8", 8'h4A);

    // R2 threshold zero acts as one
    cfg(1'b1, 4'd0);
    set_phase(2'd0, 1'b0);
    set_phase(2'd1, 1'b1);
    disk_in(8'h5D);
    chk("R2", "threshold zero as one", int'(svc_req), 1);
    disk_in(8'h5E);
    chk("R2", "fifo capacity beyond one", int'(err_overrun), 0);

    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule